// File: doc/BRIEF.md
# MSI Event Queue Writer

This block sits next to a host bridge and turns each inbound message-signalled interrupt into a 16-byte record. Records go into a circular queue held in system memory. Software sets the ring base and size and enables the block through a small register port. The block writes one record per beat through a memory master port and advances its write offset. Software consumes records and then moves the read offset forward. A level interrupt stays high while unread records remain.

Inbound messages and memory writes both use valid/ready handshakes. A message transfers on a cycle where `msg_valid` and `msg_ready` are both high. A record transfers on a cycle where `mem_valid` and `mem_ready` are both high. While the memory port stalls, a one-entry buffer holds the next message, and `msg_ready` stays low until that buffer drains.

The ring can be bounded in two ways. With full detection on, a message that would make the write offset equal the read offset is a full hit. If stop-on-full is also set, that message is dropped. Otherwise the oldest record is overwritten and the read offset is pushed forward by one record.

Top module: `msi_evq_writer`

## Requirements
- R1: Registers sit at word addresses 0 (control), 3 (base upper 32 bits), 4 (base lower 32 bits), 5 (read offset) and 6 (write offset). Base and read offset read back what was written, and the read offset is stored with bits 3:0 forced to zero.
- R2: Each record goes to base + write offset as one 128-bit beat. Bits 15:0 carry the vector and every other bit is zero.
- R3: The write offset starts at 0 and advances by 0x10 for each record issued. It wraps modulo the ring size, which is 2^(15+code) bytes for the control bits 9:8 code.
- R4: `irq` is high exactly when control bit 3 is set and the read offset and write offset differ after masking with the ring size.
- R5: Writes to the write offset register have no effect.
- R6: When control bits 1 and 4 are both set, a message whose record would make the write offset equal the read offset is dropped. No beat is issued, the write offset holds, and control bit 16 reads 1 until a control write with bit 16 set clears it.
- R7: When control bit 1 is set and bit 4 is clear, such a message is written anyway. The write offset advances and the read offset advances by 0x10.
- R8: When control bit 0 is clear, messages are accepted and discarded, with no beat and no change of offsets. With control bit 3 clear, `irq` is low.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_data` hold their values. A second message is buffered and `msg_ready` stays low until the buffer drains, and records leave in arrival order.
- R10: Changing the size code changes the offset comparison mask, so read offsets 0x8060 and 0x60 match under code 0 but not under code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| msg_valid | input | 1 | Inbound message valid |
| msg_ready | output | 1 | Inbound message ready |
| msg_vector | input | 16 | Interrupt vector carried by the message |
| mem_valid | output | 1 | Record write valid |
| mem_ready | input | 1 | Record write accepted |
| mem_addr | output | 64 | Byte address of the record |
| mem_data | output | 128 | Record contents, little-endian |
| irq | output | 1 | Level interrupt to the processor |

## Verification
The assertions assume that the inputs follow the handshake rules: `msg_vector` is stable while `msg_valid` is high, and nothing changes the ring base while a record is in flight. The stimulus drives `msg_valid` only for one cycle in which `msg_ready` is already high. It changes `mem_ready` and the registers only on falling edges, and only while no record is pending, except in the deliberate stall case.

// File: rtl/msi_evq_pkg.sv
package msi_evq_pkg;
  localparam int OFF_W   = 18;   // widest ring: 256 KB
  localparam int ADDR_W  = 64;
  localparam int REC_W   = 128;
  localparam int REC_LOG = 4;    // 16-byte records

  localparam logic [2:0] RA_CTRL    = 3'd0;
  localparam logic [2:0] RA_BASE_HI = 3'd3;
  localparam logic [2:0] RA_BASE_LO = 3'd4;
  localparam logic [2:0] RA_RD_OFF  = 3'd5;
  localparam logic [2:0] RA_WR_OFF  = 3'd6;

  localparam int CB_EN     = 0;
  localparam int CB_FULLDT = 1;
  localparam int CB_IRQEN  = 3;
  localparam int CB_STOP   = 4;
  localparam int CB_SZ     = 8;
  localparam int CB_STICKY = 16;

  typedef struct packed {
    logic       en;
    logic       full_det;
    logic       irq_en;
    logic       stop;
    logic [1:0] sz;
  } ctrl_t;

  function automatic logic [OFF_W-1:0] ring_mask(input logic [1:0] code);
    logic [OFF_W-1:0] ones;
    ones = {OFF_W{1'b1}} >> (2'd3 - code);
    return ones & {{(OFF_W-REC_LOG){1'b1}}, {REC_LOG{1'b0}}};
  endfunction
endpackage

// File: rtl/msi_evq_regs.sv
module msi_evq_regs
  import msi_evq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [OFF_W-1:0] wr_off,
  input  logic             ro_bump,
  input  logic             full_hit,
  output ctrl_t            ctrl,
  output logic [ADDR_W-1:0] base,
  output logic [OFF_W-1:0] rd_off,
  output logic             irq
);
  logic [31:0]      base_hi, base_lo;
  logic             sticky;
  logic [OFF_W-1:0] mask;

  assign mask = ring_mask(ctrl.sz);
  assign base = {base_hi, base_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      base_hi <= '0;
      base_lo <= '0;
      rd_off  <= '0;
      sticky  <= 1'b0;
    end else begin
      if (reg_we && reg_addr == RA_CTRL) begin
        ctrl.en       <= reg_wdata[CB_EN];
        ctrl.full_det <= reg_wdata[CB_FULLDT];
        ctrl.irq_en   <= reg_wdata[CB_IRQEN];
        ctrl.stop     <= reg_wdata[CB_STOP];
        ctrl.sz       <= reg_wdata[CB_SZ+1:CB_SZ];
        if (reg_wdata[CB_STICKY]) sticky <= 1'b0;
      end
      if (full_hit) sticky <= 1'b1;
      if (reg_we && reg_addr == RA_BASE_HI) base_hi <= reg_wdata;
      if (reg_we && reg_addr == RA_BASE_LO) base_lo <= reg_wdata;
      if (reg_we && reg_addr == RA_RD_OFF)
        rd_off <= {reg_wdata[OFF_W-1:REC_LOG], {REC_LOG{1'b0}}};
      else if (ro_bump)
        rd_off <= (rd_off + OFF_W'(1 << REC_LOG)) & mask;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[CB_EN]           = ctrl.en;
        reg_rdata[CB_FULLDT]       = ctrl.full_det;
        reg_rdata[CB_IRQEN]        = ctrl.irq_en;
        reg_rdata[CB_STOP]         = ctrl.stop;
        reg_rdata[CB_SZ+1:CB_SZ]   = ctrl.sz;
        reg_rdata[CB_STICKY]       = sticky;
      end
      RA_BASE_HI: reg_rdata = base_hi;
      RA_BASE_LO: reg_rdata = base_lo;
      RA_RD_OFF:  reg_rdata = 32'(rd_off);
      RA_WR_OFF:  reg_rdata = 32'(wr_off);
      default:    reg_rdata = '0;
    endcase
  end

  assign irq = ctrl.irq_en && ((rd_off & mask) != (wr_off & mask));

  // R7
  overwrite_moves_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_bump && !(reg_we && reg_addr == RA_RD_OFF) |=> rd_off != $past(rd_off));
endmodule

// File: rtl/msi_evq_inbuf.sv
module msi_evq_inbuf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic held;

  assign in_ready  = !held;
  assign out_valid = held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      out_data <= '0;
    end else if (in_valid && in_ready) begin
      held     <= 1'b1;
      out_data <= in_data;
    end else if (out_ready) begin
      held     <= 1'b0;
    end
  end

  // R9
  held_entry_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/msi_evq_wr.sv
module msi_evq_wr
  import msi_evq_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VEC_W-1:0]  in_vec,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [REC_W-1:0]  mem_data,
  output logic [OFF_W-1:0]  wr_off,
  output logic              ro_bump,
  output logic              full_hit
);
  logic [OFF_W-1:0] mask, wo_adv;
  logic full_now, take, drop, issue;

  assign mask     = ring_mask(ctrl.sz);
  assign wo_adv   = (wr_off + OFF_W'(1 << REC_LOG)) & mask;
  assign full_now = ctrl.full_det && (wo_adv == (rd_off & mask));
  assign in_ready = !mem_valid || mem_ready;
  assign take     = in_valid && in_ready;
  assign drop     = !ctrl.en || (full_now && ctrl.stop);
  assign issue    = take && !drop;
  assign ro_bump  = issue && full_now;
  assign full_hit = take && ctrl.en && full_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      wr_off    <= '0;
    end else begin
      if (mem_valid && mem_ready) mem_valid <= 1'b0;
      if (issue) begin
        mem_valid <= 1'b1;
        mem_addr  <= base + ADDR_W'(wr_off & mask);
        mem_data  <= REC_W'(in_vec);
        wr_off    <= wo_adv;
      end
    end
  end

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
  // R8
  issue_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(wr_off) |-> $past(ctrl.en));
  // R6
  stop_holds_wo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && ctrl.stop && full_now |=> $stable(wr_off));
  // R3
  wo_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $changed(wr_off));
endmodule

// File: rtl/msi_evq_writer.sv
module msi_evq_writer
  import msi_evq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [2:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  input  logic         msg_valid,
  output logic         msg_ready,
  input  logic [15:0]  msg_vector,
  output logic         mem_valid,
  input  logic         mem_ready,
  output logic [63:0]  mem_addr,
  output logic [127:0] mem_data,
  output logic         irq
);
  localparam int VEC_W = 16;

  ctrl_t              ctrl;
  logic [ADDR_W-1:0]  base;
  logic [OFF_W-1:0]   rd_off, wr_off;
  logic               ro_bump, full_hit;
  logic               b_valid, b_ready;
  logic [VEC_W-1:0]   b_vec;

  msi_evq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_off(wr_off),
    .ro_bump(ro_bump), .full_hit(full_hit), .ctrl(ctrl), .base(base),
    .rd_off(rd_off), .irq(irq)
  );

  msi_evq_inbuf #(.W(VEC_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(msg_valid), .in_ready(msg_ready),
    .in_data(msg_vector), .out_valid(b_valid), .out_ready(b_ready),
    .out_data(b_vec)
  );

  msi_evq_wr #(.VEC_W(VEC_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .base(base), .rd_off(rd_off),
    .in_valid(b_valid), .in_ready(b_ready), .in_vec(b_vec),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .wr_off(wr_off), .ro_bump(ro_bump),
    .full_hit(full_hit)
  );

  // R4
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl.irq_en && (rd_off != wr_off));
endmodule

// File: tb/sim_msi_evq_writer.sv
module sim_msi_evq_writer;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] BASE = 64'h1_8000_0000;
  localparam int NTAB = 6;
  // {vector, expected write offset of the record}
  localparam logic [31:0] TAB [NTAB] = '{
    {16'h0001, 16'h0000}, {16'hFFFF, 16'h0010}, {16'h1234, 16'h0020},
    {16'h8000, 16'h0030}, {16'h00A5, 16'h0040}, {16'h7FFE, 16'h0050}};

  logic clk = 0, rst_n = 0, reg_we = 0, msg_valid = 0, mem_ready = 1;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [15:0] msg_vector = 0;
  logic msg_ready, mem_valid, irq;
  logic [63:0] mem_addr;
  logic [127:0] mem_data;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_evq_writer u0 (.*);

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic send(logic [15:0] v);
    @(negedge clk);
    while (!msg_ready) @(negedge clk);
    msg_valid = 1; msg_vector = v;
    @(negedge clk); msg_valid = 0;
  endtask

  task automatic beat(output logic [63:0] a, output logic [127:0] d, output bit got);
    got = 0;
    for (int i = 0; i < 40 && !got; i++) begin
      if (mem_valid && mem_ready) begin a = mem_addr; d = mem_data; got = 1; end
      @(negedge clk);
    end
  endtask

  task automatic no_beat(string req, int n);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      if (mem_valid) seen = 1;
      @(negedge clk);
    end
    chk(req, seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [63:0] a;
    logic [127:0] d;
    bit got;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    chk("R9 reset ready", msg_ready, 1);
    chk("R2 reset mem_valid", mem_valid, 0);
    chk("R4 reset irq", irq, 0);
    rd(3'd0, r); chk("R1 reset ctrl", r, 0);
    rd(3'd6, r); chk("R3 reset wo", r, 0);

    wr(3'd3, 32'h1); wr(3'd4, 32'h8000_0000);
    rd(3'd3, r); chk("R1 base hi", r, 32'h1);
    rd(3'd4, r); chk("R1 base lo", r, 32'h8000_0000);
    wr(3'd0, 32'h9);

    // R2 R3 table walk
    for (int k = 0; k < NTAB; k++) begin
      send(TAB[k][31:16]);
      beat(a, d, got);
      chk("R2 beat seen", got, 1);
      chk("R2 addr", a, BASE + 64'(TAB[k][15:0]));
      chk("R2 data", d, 128'(TAB[k][31:16]));
    end
    rd(3'd6, r); chk("R3 wo after table", r, 32'h60);
    chk("R4 irq pending", irq, 1);
    wr(3'd6, 32'h1230);
    rd(3'd6, r); chk("R5 wo read-only", r, 32'h60);
    wr(3'd5, 32'h6F);
    rd(3'd5, r); chk("R1 ro aligned", r, 32'h60);
    chk("R4 irq cleared", irq, 0);

    // R10 size mask
    wr(3'd5, 32'h8060);
    chk("R10 code0 match", irq, 0);
    wr(3'd0, 32'h109);
    chk("R10 code1 differ", irq, 1);
    wr(3'd5, 32'h60); wr(3'd0, 32'h9);

    // R9 back-pressure
    mem_ready = 0;
    send(16'hAAAA);
    send(16'hBBBB);
    for (int i = 0; i < 3; i++) begin
      chk("R9 ready low", msg_ready, 0);
      chk("R9 addr held", mem_addr, BASE + 64'h60);
      @(negedge clk);
    end
    mem_ready = 1;
    beat(a, d, got); chk("R9 first", d, 128'hAAAA);
    beat(a, d, got); chk("R9 second", d, 128'hBBBB);
    chk("R9 second addr", a, BASE + 64'h70);

    // R8 disabled
    wr(3'd0, 32'h8);
    send(16'h5555);
    no_beat("R8 no beat", 10);
    rd(3'd6, r); chk("R8 wo kept", r, 32'h80);
    chk("R8 irq still on", irq, 1);
    wr(3'd0, 32'h0);
    chk("R8 irq off", irq, 0);

    // R3 wrap
    wr(3'd0, 32'h9);
    for (int k = 0; k < 2040; k++) begin
      send(16'(k));
      beat(a, d, got);
    end
    chk("R3 last addr", a, BASE + 64'h7FF0);
    rd(3'd6, r); chk("R3 wrapped", r, 0);

    // R6 full stop
    wr(3'd0, 32'h1B); wr(3'd5, 32'h20);
    send(16'h0C01);
    beat(a, d, got); chk("R6 pre-full addr", a, BASE);
    send(16'h0C02);
    no_beat("R6 dropped", 10);
    rd(3'd6, r); chk("R6 wo held", r, 32'h10);
    rd(3'd0, r); chk("R6 sticky", r, 32'h1001B);
    wr(3'd0, 32'h1001B);
    rd(3'd0, r); chk("R6 sticky clear", r, 32'h1B);

    // R7 overwrite
    wr(3'd0, 32'hB);
    send(16'h0C03);
    beat(a, d, got); chk("R7 addr", a, BASE + 64'h10);
    rd(3'd6, r); chk("R7 wo", r, 32'h20);
    rd(3'd5, r); chk("R7 ro bumped", r, 32'h30);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule